// File: doc/BRIEF.md
# ATA Programmed-I/O Cycle Engine

This block sits between a word-spaced CPU register port and a parallel ATA device bus and runs programmed-I/O bus cycles on the host side. Every cycle has three phases: address setup, then strobe active, then recovery. Each phase takes its length, counted in controller clocks, from a single packed timing word. A CPU write to a task-file address turns into a device write cycle.

A CPU read of a task-file address does not return device data. It only starts a device read cycle. The captured value is collected later from a separate read-data register. Software polls a busy nibble in the status register until it reads zero, then issues the next access. One access can wait in a pending slot while another is on the bus.

The engine also provides the enable control, a byte-swap option for 16-bit data, IORDY stretching of the strobe when a configuration bit allows it, and a five-bit interrupt status with write-one-to-clear and a mask.

Register map, as byte offsets:

| Offset | Contents |
|---|---|
| 0x00 | Control. Bit 0 is the enable. |
| 0x04 | Configuration. Bit 0 is the IORDY enable, bit 1 is the byte swap. |
| 0x08 | Timing word. |
| 0x0C | Status. Bits [31:28] are the busy nibble. |
| 0x10 | Interrupt status. |
| 0x14 | Interrupt mask. |
| 0x18 | Read data. |
| 0x20 + 4*i | Task-file register i, for i = 0 to 7. |

Top module: `ata_pio_engine`

## Requirements
- R1: The timing word at 0x08 holds three counts: setup in bits [3:0], strobe-active in bits [11:4] and recovery in bits [19:12]. A cycle holds `ataCsN` low for setup clocks with both strobes high, then strobe clocks with one strobe low, then recovery clocks with both strobes high, in that order.
- R2: A timing field of 0 gives a phase of 1 clock.
- R3: When configuration bit 0 is 1, a low `ataIordy` holds the strobe phase past its count, until `ataIordy` is seen high. When the bit is 0, `ataIordy` has no effect on any phase length.
- R4: Status bits [31:28] read non-zero while a cycle is running or an access is pending, and read zero otherwise. Bit 28 means a cycle is on the bus. Bit 29 means an access is pending.
- R5: A read strobe (`regRdEn`) at a task-file address starts a device read cycle and returns 0 on `regRdData`. The value captured at the end of the strobe phase can then be read at 0x18.
- R6: Task-file register i sits at byte offset 0x20 + 4*i, and i is driven on `ataAddr`. Register 0 carries 16 bits. Registers 1 to 7 carry only the low byte, and the upper byte is 0 both on `ataDataOut` and in the read data.
- R7: While control bit 0 is 0, no bus cycle starts. An access issued in that state stays pending and runs once the bit is set.
- R8: Configuration bit 1 swaps the two bytes of task-file register 0, in both directions. Registers 1 to 7 are never swapped.
- R9: Interrupt status at 0x10 has 5 bits. Bit i is set by `evtIn[i]`, and bit 0 is also set when a cycle completes. Writing 1 to a bit clears it. `irqOut` is the OR of status AND mask, with the mask at 0x14.
- R10: `ataCsN` and `ataAddr` stay unchanged from the start of setup to the end of recovery. `ataRdN` and `ataWrN` are active low and are never low together.
- R11: An access issued while a cycle runs is held in a one-entry pending slot, and runs after the current cycle. A further access issued while that slot is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | CPU register write strobe |
| regRdEn | input | 1 | CPU register read strobe; starts a device read at task-file addresses |
| regAddr | input | 6 | CPU byte address |
| regWrData | input | 32 | CPU write data |
| regRdData | output | 32 | CPU read data for `regAddr` |
| evtIn | input | 5 | Interrupt event pulses |
| irqOut | output | 1 | Masked interrupt request |
| ataCsN | output | 1 | Device chip select, active low |
| ataAddr | output | 3 | Task-file register index |
| ataRdN | output | 1 | Read strobe, active low |
| ataWrN | output | 1 | Write strobe, active low |
| ataIordy | input | 1 | Device ready; low stretches the strobe |
| ataDataIn | input | 16 | Data from the device |
| ataDataOut | output | 16 | Data to the device |
| ataDataOe | output | 1 | Output enable for `ataDataOut` during write cycles |

## Verification
The bench sweeps setup, strobe and recovery counts, including zero fields and the largest setup value. Off-by-one counter loading would show up as phases one clock long or short, and a zero field taken literally would collapse or wrap a phase. IORDY is held low for more and for fewer clocks than the programmed strobe count, with the enable bit on and off: a design that ignored the bit, or stretched from the wrong edge, would give the wrong strobe width. Byte swap and byte-wide registers are checked in both directions, as is the back-to-back case where one access is pending and a third must be ignored. A broken pending slot would lose, reorder or duplicate a cycle.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_RECOV} pioPhaseT;

  typedef struct packed {
    logic launch;
    logic capture;
    logic done;
  } pioStrobeT;

  localparam int REG_AW = 6;
  localparam logic [REG_AW-1:0] OFF_CTRL  = 6'h00;
  localparam logic [REG_AW-1:0] OFF_CFG   = 6'h04;
  localparam logic [REG_AW-1:0] OFF_TIME  = 6'h08;
  localparam logic [REG_AW-1:0] OFF_STAT  = 6'h0C;
  localparam logic [REG_AW-1:0] OFF_IRQ   = 6'h10;
  localparam logic [REG_AW-1:0] OFF_MASK  = 6'h14;
  localparam logic [REG_AW-1:0] OFF_RDATA = 6'h18;
endpackage

// File: rtl/ata_pio_ctrl.sv
module ata_pio_ctrl
  import ata_pio_pkg::*;
#(
  parameter int SETUP_W = 4,
  parameter int PULSE_W = 8,
  parameter int RECOV_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               pendValid,
  input  logic               iordyEn,
  input  logic               iordy,
  input  logic [SETUP_W-1:0] setupLen,
  input  logic [PULSE_W-1:0] pulseLen,
  input  logic [RECOV_W-1:0] recovLen,
  output pioPhaseT           phase,
  output pioStrobeT          strb
);
  localparam int MAX_SP = (SETUP_W > PULSE_W) ? SETUP_W : PULSE_W;
  localparam int CNT_W  = (MAX_SP > RECOV_W) ? MAX_SP : RECOV_W;

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] lenToCnt(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_comb begin
    strb.launch  = (phase == PH_IDLE) && enable && pendValid;
    strb.capture = (phase == PH_STROBE) && (cnt == '0) && (!iordyEn || iordy);
    strb.done    = (phase == PH_RECOV) && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (strb.launch) begin
          phase <= PH_SETUP;
          cnt   <= lenToCnt(CNT_W'(setupLen));
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_STROBE;
          cnt   <= lenToCnt(CNT_W'(pulseLen));
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (strb.capture) begin
          phase <= PH_RECOV;
          cnt   <= lenToCnt(CNT_W'(recovLen));
        end else if (cnt != '0) cnt <= cnt - 1'b1;
        PH_RECOV: if (cnt == '0) phase <= PH_IDLE;
                  else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R1: strobe is entered only from setup, recovery only from strobe
  assert_order_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE) |-> ($past(phase) == PH_SETUP || $past(phase) == PH_STROBE));
  assert_order_recov_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RECOV) |-> ($past(phase) == PH_STROBE || $past(phase) == PH_RECOV));
  // R3: with the IORDY enable clear, an expired strobe count always ends the strobe
  assert_iordy_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE && cnt == '0 && !iordyEn) |=> (phase == PH_RECOV));
  // R7: no cycle leaves idle while disabled
  assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && !enable) |=> (phase == PH_IDLE));
endmodule

// File: rtl/ata_pio_datapath.sv
module ata_pio_datapath
  import ata_pio_pkg::*;
#(
  parameter int SETUP_W = 4,
  parameter int PULSE_W = 8,
  parameter int RECOV_W = 8,
  parameter int IRQ_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [IRQ_W-1:0]   evtIn,
  output logic               irqOut,
  input  pioPhaseT           phase,
  input  pioStrobeT          strb,
  output logic               enable,
  output logic               pendValid,
  output logic               iordyEn,
  output logic [SETUP_W-1:0] setupLen,
  output logic [PULSE_W-1:0] pulseLen,
  output logic [RECOV_W-1:0] recovLen,
  input  logic [15:0]        ataDataIn,
  output logic [15:0]        ataDataOut,
  output logic               ataDataOe,
  output logic [2:0]         ataAddr,
  output logic               ataCsN,
  output logic               ataRdN,
  output logic               ataWrN
);
  localparam int TIME_W = SETUP_W + PULSE_W + RECOV_W;

  logic              cfgSwap;
  logic [TIME_W-1:0] timeWord;
  logic [IRQ_W-1:0]  irqStat, irqMask;
  logic [15:0]       rdData;
  logic              pendWrite, curWrite;
  logic [2:0]        pendIdx, curIdx;
  logic [15:0]       pendData, curData;
  logic              tfHit, accept, irqClr;

  function automatic logic [15:0] laneMap(input logic [2:0] idx, input logic swap,
                                          input logic [15:0] d);
    if (idx != 3'd0) return {8'h00, d[7:0]};
    return swap ? {d[7:0], d[15:8]} : d;
  endfunction

  assign tfHit    = regAddr[5];
  assign accept   = (regWrEn || regRdEn) && tfHit && (!pendValid || strb.launch);
  assign irqClr   = regWrEn && (regAddr == OFF_IRQ);
  assign setupLen = timeWord[SETUP_W-1:0];
  assign pulseLen = timeWord[SETUP_W +: PULSE_W];
  assign recovLen = timeWord[SETUP_W+PULSE_W +: RECOV_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0; iordyEn <= 1'b0; cfgSwap <= 1'b0;
      timeWord <= '0; irqMask <= '0; rdData <= '0;
    end else begin
      if (regWrEn && regAddr == OFF_CTRL) enable <= regWrData[0];
      if (regWrEn && regAddr == OFF_CFG) begin
        iordyEn <= regWrData[0];
        cfgSwap <= regWrData[1];
      end
      if (regWrEn && regAddr == OFF_TIME) timeWord <= regWrData[TIME_W-1:0];
      if (regWrEn && regAddr == OFF_MASK) irqMask <= regWrData[IRQ_W-1:0];
      if (strb.capture && !curWrite) rdData <= laneMap(curIdx, cfgSwap, ataDataIn);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0; pendWrite <= 1'b0; pendIdx <= '0; pendData <= '0;
      curWrite <= 1'b0; curIdx <= '0; curData <= '0;
    end else begin
      if (accept) begin
        pendValid <= 1'b1;
        pendWrite <= regWrEn;
        pendIdx   <= regAddr[4:2];
        pendData  <= regWrData[15:0];
      end else if (strb.launch) begin
        pendValid <= 1'b0;
      end
      if (strb.launch) begin
        curWrite <= pendWrite;
        curIdx   <= pendIdx;
        curData  <= pendData;
      end
    end
  end

  for (genvar b = 0; b < IRQ_W; b++) begin : g_irq
    logic bitQ, setB;
    assign setB = evtIn[b] | ((b == 0) ? strb.done : 1'b0);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bitQ <= 1'b0;
      else if (setB) bitQ <= 1'b1;
      else if (irqClr && regWrData[b]) bitQ <= 1'b0;
    end
    assign irqStat[b] = bitQ;
  end

  assign irqOut = |(irqStat & irqMask);

  always_comb begin
    unique case (regAddr)
      OFF_CTRL:  regRdData = {31'd0, enable};
      OFF_CFG:   regRdData = {30'd0, cfgSwap, iordyEn};
      OFF_TIME:  regRdData = 32'(timeWord);
      OFF_STAT:  regRdData = {2'b00, pendValid, (phase != PH_IDLE), 28'd0};
      OFF_IRQ:   regRdData = 32'(irqStat);
      OFF_MASK:  regRdData = 32'(irqMask);
      OFF_RDATA: regRdData = {16'd0, rdData};
      default:   regRdData = 32'd0;
    endcase
  end

  assign ataCsN     = (phase == PH_IDLE);
  assign ataRdN     = !(phase == PH_STROBE && !curWrite);
  assign ataWrN     = !(phase == PH_STROBE && curWrite);
  assign ataDataOe  = (phase != PH_IDLE) && curWrite;
  assign ataAddr    = curIdx;
  assign ataDataOut = laneMap(curIdx, cfgSwap, curData);

  logic unusedBits;
  assign unusedBits = ^{regWrData[31:TIME_W], regAddr[1:0]};

  // R10: the two strobes are never active together
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(!ataRdN && !ataWrN));
  // R10: the address holds through the whole bus cycle
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(ataAddr));
  // R7: a pending access survives while disabled
  assert_pend_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !enable) |=> pendValid);
  // R9: write-one clears interrupt bit 0 when no set source is present
  assert_irq_w1c_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && regWrData[0] && !evtIn[0] && !strb.done) |=> !irqStat[0]);
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int SETUP_W = 4,
  parameter int PULSE_W = 8,
  parameter int RECOV_W = 8,
  parameter int IRQ_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [IRQ_W-1:0]  evtIn,
  output logic              irqOut,
  output logic              ataCsN,
  output logic [2:0]        ataAddr,
  output logic              ataRdN,
  output logic              ataWrN,
  input  logic              ataIordy,
  input  logic [15:0]       ataDataIn,
  output logic [15:0]       ataDataOut,
  output logic              ataDataOe
);
  pioPhaseT           phase;
  pioStrobeT          strb;
  logic               enable, pendValid, iordyEn;
  logic [SETUP_W-1:0] setupLen;
  logic [PULSE_W-1:0] pulseLen;
  logic [RECOV_W-1:0] recovLen;

  ata_pio_ctrl #(.SETUP_W(SETUP_W), .PULSE_W(PULSE_W), .RECOV_W(RECOV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .pendValid(pendValid),
    .iordyEn(iordyEn), .iordy(ataIordy), .setupLen(setupLen),
    .pulseLen(pulseLen), .recovLen(recovLen), .phase(phase), .strb(strb)
  );

  ata_pio_datapath #(.SETUP_W(SETUP_W), .PULSE_W(PULSE_W), .RECOV_W(RECOV_W),
                     .IRQ_W(IRQ_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .evtIn(evtIn), .irqOut(irqOut), .phase(phase), .strb(strb),
    .enable(enable), .pendValid(pendValid), .iordyEn(iordyEn),
    .setupLen(setupLen), .pulseLen(pulseLen), .recovLen(recovLen),
    .ataDataIn(ataDataIn), .ataDataOut(ataDataOut), .ataDataOe(ataDataOe),
    .ataAddr(ataAddr), .ataCsN(ataCsN), .ataRdN(ataRdN), .ataWrN(ataWrN)
  );
endmodule

// File: tb/ata_pio_engine_bench.sv
module ata_pio_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [4:0]  evtIn = '0;
  logic        irqOut, ataCsN, ataRdN, ataWrN, ataDataOe;
  logic [2:0]  ataAddr;
  logic        ataIordy = 1'b1;
  logic [15:0] ataDataIn = '0;
  logic [15:0] ataDataOut;

  int total = 0, bad = 0;

  ata_pio_engine u_ata_pio_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .evtIn(evtIn), .irqOut(irqOut), .ataCsN(ataCsN), .ataAddr(ataAddr),
    .ataRdN(ataRdN), .ataWrN(ataWrN), .ataIordy(ataIordy),
    .ataDataIn(ataDataIn), .ataDataOut(ataDataOut), .ataDataOe(ataDataOe)
  );

  always #10 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic checkEq(input string req, input string what,
                         input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #2; d = regRdData;
  endtask

  task automatic tfRead(input int idx);
    @(negedge clk); regAddr = 6'(32 + 4 * idx); regRdEn = 1'b1;
    #2; checkEq("R5", "read data bus at task-file address", regRdData, 0);
    @(negedge clk); regRdEn = 1'b0;
  endtask

  int mSetup, mPulse, mRecov, mBoth, mMoved;
  logic [2:0]  mAddr;
  logic [15:0] mData;

  task automatic measure(input int hold);
    bit started = 0;
    mSetup = 0; mPulse = 0; mRecov = 0; mBoth = 0; mMoved = 0;
    ataIordy = (hold == 0);
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk); #1;
      if (!ataCsN) begin
        if (!started) mAddr = ataAddr;
        started = 1;
        if (ataAddr != mAddr) mMoved++;
        if (!ataRdN && !ataWrN) mBoth++;
        if (!ataRdN || !ataWrN) begin
          mPulse++; mData = ataDataOut;
          if (mPulse >= hold) ataIordy = 1'b1;
        end else if (mPulse == 0) mSetup++;
        else mRecov++;
      end else if (started) break;
    end
    ataIordy = 1'b1;
  endtask

  function automatic int min1(input int v); return (v == 0) ? 1 : v; endfunction
  function automatic int maxOf(input int a, input int b); return (a > b) ? a : b; endfunction

  int sv[5] = '{0, 1, 2, 7, 15};
  int pv[4] = '{0, 1, 3, 9};
  int rv[3] = '{0, 1, 5};
  int hv[5] = '{0, 1, 2, 5, 9};

  initial begin
    logic [31:0] rd;
    int n = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    checkEq("R10", "cs at reset", ataCsN, 1);
    checkEq("R10", "strobes at reset", {ataRdN, ataWrN}, 2'b11);
    checkEq("R9", "irq at reset", irqOut, 0);
    regRead(6'h0C, rd); checkEq("R4", "status at reset", rd, 0);
    regRead(6'h00, rd); checkEq("R7", "control at reset", rd, 0);

    regWrite(6'h00, 1);
    // timing sweep over all three fields (R1, R2, R6)
    for (int si = 0; si < 5; si++)
      for (int pi = 0; pi < 4; pi++)
        for (int ri = 0; ri < 3; ri++) begin
          int idx = n % 8;
          logic [15:0] d = 16'(16'h5A00 ^ (sv[si] << 8) ^ (pv[pi] << 4) ^ rv[ri] ^ n);
          logic [15:0] expD = (idx == 0) ? d : {8'h00, d[7:0]};
          n++;
          regWrite(6'h08, (rv[ri] << 12) | (pv[pi] << 4) | sv[si]);
          regWrite(6'(32 + 4 * idx), {16'hFFFF, d});
          measure(0);
          checkEq("R1/R2", "setup clocks", mSetup, min1(sv[si]));
          checkEq("R1/R2", "strobe clocks", mPulse, min1(pv[pi]));
          checkEq("R1/R2", "recovery clocks", mRecov, min1(rv[ri]));
          checkEq("R6", "task-file index", mAddr, idx);
          checkEq("R6", "write data lanes", mData, expD);
          checkEq("R10", "address moved in cycle", mMoved, 0);
          checkEq("R10", "both strobes low", mBoth, 0);
        end
    regRead(6'h0C, rd); checkEq("R4", "busy after sweep", rd[31:28], 0);

    // IORDY stretching (R3)
    regWrite(6'h08, (1 << 12) | (2 << 4) | 1);
    regWrite(6'h04, 1);
    for (int hi = 0; hi < 5; hi++) begin
      regWrite(6'h24, 8'h33);
      measure(hv[hi]);
      checkEq("R3", "stretched strobe clocks", mPulse, maxOf(2, hv[hi]));
      checkEq("R3", "setup unaffected", mSetup, 1);
    end
    regWrite(6'h04, 0);
    regWrite(6'h24, 8'h33);
    measure(6);
    checkEq("R3", "iordy ignored when disabled", mPulse, 2);

    // two-step reads, byte lanes and swap (R5, R6, R8)
    ataDataIn = 16'h12C3;
    tfRead(0); measure(0);
    regRead(6'h18, rd); checkEq("R5", "read data register", rd, 32'h12C3);
    tfRead(3); measure(0);
    checkEq("R10", "read uses read strobe only", {mBoth, mPulse}, {32'd0, 32'd2});
    regRead(6'h18, rd); checkEq("R6", "byte register read", rd, 32'h00C3);
    regWrite(6'h04, 2);
    tfRead(0); measure(0);
    regRead(6'h18, rd); checkEq("R8", "swapped data read", rd, 32'hC312);
    tfRead(2); measure(0);
    regRead(6'h18, rd); checkEq("R8", "byte register never swapped", rd, 32'h00C3);
    regWrite(6'h20, 32'hBEEF); measure(0);
    checkEq("R8", "swapped data write", mData, 16'hEFBE);
    regWrite(6'h28, 32'hBEEF); measure(0);
    checkEq("R8", "byte write not swapped", mData, 16'h00EF);
    regWrite(6'h04, 0);

    // busy polling (R4)
    regWrite(6'h08, (3 << 12) | (4 << 4) | 3);
    regWrite(6'h2C, 8'h5E);
    regRead(6'h0C, rd); checkEq("R4", "busy during cycle", rd[31:28], 4'b0001);
    measure(0);
    regRead(6'h0C, rd); checkEq("R4", "idle after cycle", rd[31:28], 0);

    // pending slot and overflow (R11)
    begin
      int pulses = 0;
      logic [15:0] seen [3];
      logic lastWr = 1'b1;
      regWrite(6'h24, 8'h11);
      regWrite(6'h28, 8'h22);
      regRead(6'h0C, rd); checkEq("R11", "busy with pending", rd[31:28], 4'b0011);
      regWrite(6'h2C, 8'h77);
      for (int k = 0; k < 200; k++) begin
        @(posedge clk); #1;
        if (!ataWrN && lastWr && pulses < 3) begin seen[pulses] = ataDataOut; pulses++; end
        lastWr = ataWrN;
      end
      checkEq("R11", "cycle count", pulses, 2);
      checkEq("R11", "first cycle data", seen[0], 16'h0011);
      checkEq("R11", "second cycle data", seen[1], 16'h0022);
    end

    // enable gating (R7)
    regWrite(6'h00, 0);
    regWrite(6'h30, 8'h44);
    begin
      int csLow = 0;
      for (int k = 0; k < 40; k++) begin
        @(posedge clk); #1; if (!ataCsN) csLow++;
      end
      checkEq("R7", "no cycle while disabled", csLow, 0);
    end
    regRead(6'h0C, rd); checkEq("R7", "access held pending", rd[31:28], 4'b0010);
    regWrite(6'h00, 1);
    measure(0);
    checkEq("R7", "held access runs after enable", {mAddr, mData}, {3'd4, 16'h0044});

    // interrupts (R9)
    regWrite(6'h10, 32'h1F);
    regWrite(6'h14, 0);
    regRead(6'h10, rd); checkEq("R9", "status cleared", rd, 0);
    @(negedge clk); evtIn = 5'b10100;
    @(negedge clk); evtIn = '0;
    regRead(6'h10, rd); checkEq("R9", "events latched", rd, 32'h14);
    checkEq("R9", "masked off", irqOut, 0);
    regWrite(6'h14, 32'h04);
    #2; checkEq("R9", "unmasked irq", irqOut, 1);
    regWrite(6'h10, 32'h04);
    regRead(6'h10, rd); checkEq("R9", "w1c one bit", rd, 32'h10);
    checkEq("R9", "irq dropped after clear", irqOut, 0);
    regWrite(6'h24, 8'h01); measure(0);
    regRead(6'h10, rd); checkEq("R9", "completion sets bit0", rd, 32'h11);
    regWrite(6'h14, 32'h01);
    #2; checkEq("R9", "completion irq", irqOut, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule